// File: doc/BRIEF.md
# Two-Step Serial Combination Lock Controller

This block controls a door lock that opens after a two-number combination is keyed in. Each number is 2 bits wide and is set on a switch bus. The user confirms it with a one-cycle enter strobe. The user sets the first number and strobes, then sets the second number and strobes. When both numbers are correct, the open output rises in the same cycle as the second strobe. A wrong number at either step raises the error output. The machine then stays in the error condition until the reset button is pressed.

Two comparator stages reduce the switch value to a "first number matches" flag and a "second number matches" flag. A Mealy next-state and output stage combines these flags with the strobe and the reset button. Both outputs therefore react to the current inputs as well as to the stored state. The state sits in three flip-flops that share an asynchronous clear. This clear is held inactive in normal use and can be driven high to force the machine back to its start state. The two combination numbers are parameters and must differ.

Top module: `serial_lock_ctrl`

## Requirements
- R1: While `ff_clear` is high, the machine is in its start state. With the enter strobe low, both `open_o` and `error_o` read 0.
- R2: In the start state, a cycle with `enter` high and `rst_btn` low raises `error_o` in that same cycle exactly when `code` differs from `FIRST_NUM`. When `code` equals `FIRST_NUM`, both outputs stay 0.
- R3: The sequence is an enter with `code == FIRST_NUM`, then a later enter with `code == SECOND_NUM`. This sequence raises `open_o` combinationally in the cycle of the second enter.
- R4: An enter in the start state with a code other than `FIRST_NUM` moves the machine to the error state.
- R5: After a correct first number, an enter with any code other than `SECOND_NUM` raises `error_o` in that cycle. This includes `FIRST_NUM` entered again.
- R6: Once in the error state, `error_o` stays high in every cycle with `rst_btn` low, whatever `enter` and `code` do.
- R7: A cycle with `rst_btn` high drives both outputs to 0 and puts the machine in the start state at the next edge, from any state. Reset wins over a simultaneous enter, and the number entered in that cycle is discarded.
- R8: In a cycle with `enter` low and `rst_btn` low, the state does not change.
- R9: `open_o` and `error_o` are never high in the same cycle.
- R10: Once the open state is reached, `open_o` stays high in every cycle with `rst_btn` low, whatever `enter` and `code` do.
- R11: Raising `ff_clear` between clock edges returns the machine to the start state at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| ff_clear | input | 1 | Asynchronous clear of the state flip-flops, active high |
| rst_btn | input | 1 | Synchronous reset button, active high, overrides enter |
| enter | input | 1 | One-cycle strobe that submits the current switch code |
| code | input | 2 | Switch bus holding the number being entered |
| open_o | output | 1 | Lock release, combinational (Mealy) |
| error_o | output | 1 | Wrong-combination indicator, combinational (Mealy) |

## Verification
A wrong stored state always shows at the ports within one cycle. The outputs are Mealy, so the next strobe reveals it. A machine that wrongly sits in the start state raises `error_o` when the second number is entered. A machine stuck in the first-number state raises `open_o` or `error_o` on the next strobe. Error and open states are visible in every non-reset cycle, even with no strobe. The bench therefore predicts the outputs in every cycle, between drive and clock edge, and compares them there. It also probes hidden state after async clears and reset-versus-enter collisions by entering the follow-up number.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'b000,
    ST_FIRST = 3'b001,
    ST_OPEN  = 3'b010,
    ST_ERR   = 3'b100
  } lock_state_e;

  typedef struct packed {
    logic unlock;
    logic fault;
  } lock_out_s;

  // Next state from the current state and the qualified inputs.
  function automatic lock_state_e step_state(lock_state_e cur, logic rst,
                                             logic en, logic m1, logic m2);
    lock_state_e nxt;
    if (rst) begin
      nxt = ST_IDLE;
    end else begin
      unique case (cur)
        ST_IDLE:  nxt = !en ? ST_IDLE  : (m1 ? ST_FIRST : ST_ERR);
        ST_FIRST: nxt = !en ? ST_FIRST : (m2 ? ST_OPEN  : ST_ERR);
        ST_OPEN:  nxt = ST_OPEN;
        ST_ERR:   nxt = ST_ERR;
        default:  nxt = ST_IDLE;
      endcase
    end
    return nxt;
  endfunction

  // Mealy outputs: depend on the current state and the current inputs.
  function automatic lock_out_s mealy_out(lock_state_e cur, logic rst,
                                          logic en, logic m1, logic m2);
    lock_out_s o;
    o = '0;
    if (!rst) begin
      unique case (cur)
        ST_IDLE:  o.fault  = en & ~m1;
        ST_FIRST: begin
          o.unlock = en & m2;
          o.fault  = en & ~m2;
        end
        ST_OPEN:  o.unlock = 1'b1;
        ST_ERR:   o.fault  = 1'b1;
        default:  o = '0;
      endcase
    end
    return o;
  endfunction

endpackage

// File: rtl/code_match.sv
module code_match #(
  parameter int              CODE_W = 2,
  parameter logic [CODE_W-1:0] VALUE  = '0
) (
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  always_comb hit = (code == VALUE);
endmodule

// File: rtl/lock_next_logic.sv
module lock_next_logic
  import lock_pkg::*;
(
  input  lock_state_e cur,
  input  logic        rst,
  input  logic        en,
  input  logic        m1,
  input  logic        m2,
  output lock_state_e nxt,
  output logic        unlock,
  output logic        fault
);
  lock_out_s outs;

  always_comb begin
    nxt    = step_state(cur, rst, en, m1, m2);
    outs   = mealy_out(cur, rst, en, m1, m2);
    unlock = outs.unlock;
    fault  = outs.fault;
  end
endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         aclr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    always_ff @(posedge clk or posedge aclr) begin
      if (aclr) q[gi] <= 1'b0;
      else      q[gi] <= d[gi];
    end
  end
endmodule

// File: rtl/serial_lock_ctrl.sv
module serial_lock_ctrl
  import lock_pkg::*;
#(
  parameter int                CODE_W     = 2,
  parameter logic [CODE_W-1:0] FIRST_NUM  = 2'b01,
  parameter logic [CODE_W-1:0] SECOND_NUM = 2'b11
) (
  input  logic              clk,
  input  logic              ff_clear,
  input  logic              rst_btn,
  input  logic              enter,
  input  logic [CODE_W-1:0] code,
  output logic              open_o,
  output logic              error_o
);
  localparam int NUM_STEPS = 2;
  localparam logic [CODE_W-1:0] STEP_VAL [NUM_STEPS] = '{FIRST_NUM, SECOND_NUM};

  if (FIRST_NUM == SECOND_NUM) begin : g_bad_combo
    $error("serial_lock_ctrl: the two combination numbers must differ");
  end

  // Comparator stage: one match flag per combination step.
  logic [NUM_STEPS-1:0] step_hit;
  for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_cmp
    code_match #(.CODE_W(CODE_W), .VALUE(STEP_VAL[gi])) u_cmp (
      .code (code),
      .hit  (step_hit[gi])
    );
  end

  logic [STATE_W-1:0] state_q;
  lock_state_e        state_cur;
  lock_state_e        state_nxt;
  logic               unlock_w;
  logic               fault_w;

  always_comb state_cur = lock_state_e'(state_q);

  lock_next_logic u_logic (
    .cur    (state_cur),
    .rst    (rst_btn),
    .en     (enter),
    .m1     (step_hit[0]),
    .m2     (step_hit[1]),
    .nxt    (state_nxt),
    .unlock (unlock_w),
    .fault  (fault_w)
  );

  lock_state_reg #(.W(STATE_W)) u_state (
    .clk  (clk),
    .aclr (ff_clear),
    .d    (state_nxt),
    .q    (state_q)
  );

  assign open_o  = unlock_w;
  assign error_o = fault_w;

  // Assertions next to the state register they guard.
  p_legal_state_r1: assert property (@(posedge clk) disable iff (ff_clear)
    $onehot0(state_q));

  p_one_output_r9: assert property (@(posedge clk) disable iff (ff_clear)
    !(open_o && error_o));

  p_reset_idle_r7: assert property (@(posedge clk) disable iff (ff_clear)
    rst_btn |=> (state_cur == ST_IDLE));

  p_hold_no_enter_r8: assert property (@(posedge clk) disable iff (ff_clear)
    (!enter && !rst_btn) |=> $stable(state_q));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (ff_clear)
    (state_cur == ST_ERR && !rst_btn) |=> (state_cur == ST_ERR));

  p_open_sticky_r10: assert property (@(posedge clk) disable iff (ff_clear)
    (state_cur == ST_OPEN && !rst_btn) |=> (state_cur == ST_OPEN));

  p_second_ok_r3: assert property (@(posedge clk) disable iff (ff_clear)
    (state_cur == ST_FIRST && enter && !rst_btn && code == SECOND_NUM)
      |=> (state_cur == ST_OPEN));

  p_first_bad_r4: assert property (@(posedge clk) disable iff (ff_clear)
    (state_cur == ST_IDLE && enter && !rst_btn && code != FIRST_NUM)
      |=> (state_cur == ST_ERR));

endmodule

// File: tb/serial_lock_ctrl_tb.sv
`timescale 1ns/1ps
module serial_lock_ctrl_tb;
  localparam logic [1:0] N1 = 2'b10;
  localparam logic [1:0] N2 = 2'b01;

  logic       clk = 1'b0;
  logic       ff_clear = 1'b1;
  logic       rst_btn = 1'b0;
  logic       enter = 1'b0;
  logic [1:0] code = 2'b00;
  logic       open_o, error_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mst = 0; // bench model: 0 start, 1 first ok, 2 opened, 3 error

  always #2.5 clk = ~clk;

  serial_lock_ctrl #(.CODE_W(2), .FIRST_NUM(N1), .SECOND_NUM(N2)) u_dut (
    .clk(clk), .ff_clear(ff_clear), .rst_btn(rst_btn), .enter(enter),
    .code(code), .open_o(open_o), .error_o(error_o)
  );

  function automatic logic [1:0] exp_out(int s, logic r, logic e, logic [1:0] c);
    if (r) return 2'b00;
    case (s)
      0: return (e && c != N1) ? 2'b01 : 2'b00;
      1: return !e ? 2'b00 : ((c == N2) ? 2'b10 : 2'b01);
      2: return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int exp_next(int s, logic r, logic e, logic [1:0] c);
    if (r) return 0;
    if (!e) return s;
    if (s == 0) return (c == N1) ? 1 : 3;
    if (s == 1) return (c == N2) ? 2 : 3;
    return s;
  endfunction

  task automatic chk(string tag);
    logic [1:0] ex;
    ex = exp_out(mst, rst_btn, enter, code);
    checks++;
    if ({open_o, error_o} !== ex) begin
      errors++;
      $display("FAIL %s: open/error=%b%b expected %b%b (state %0d)",
               tag, open_o, error_o, ex[1], ex[0], mst);
    end
    checks++;
    if (open_o && error_o) begin
      errors++;
      $display("FAIL R9: open/error=11 expected not both");
    end
  endtask

  task automatic step(logic r, logic e, logic [1:0] c, string tag);
    @(negedge clk);
    rst_btn = r; enter = e; code = c;
    #1;
    chk(tag);
    @(posedge clk);
    mst = exp_next(mst, r, e, c);
  endtask

  task automatic async_clear(string tag);
    @(negedge clk);
    rst_btn = 0; enter = 0; code = 2'b00;
    #0.5;
    ff_clear = 1;
    #0.5;
    mst = 0;
    chk(tag);
    @(negedge clk);
    ff_clear = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    #12;
    chk("R1");
    @(negedge clk);
    ff_clear = 0;
    step(0, 0, 2'b00, "R1");

    // R2: every code at the start state
    for (int v = 0; v < 4; v++) begin
      step(0, 1, v[1:0], "R2");
      step(1, 0, 2'b00, "R7");
    end

    // R3 / R10: correct sequence, then open held against noise
    step(0, 1, N1, "R3");
    step(0, 0, 2'b11, "R8");
    step(0, 0, N2, "R8");
    step(0, 1, N2, "R3");
    step(0, 1, N1, "R10");
    step(0, 0, 2'b00, "R10");
    step(0, 1, 2'b11, "R10");
    step(1, 1, N2, "R7");
    step(0, 0, 2'b00, "R7");

    // R4 / R6
    step(0, 1, N2, "R4");
    step(0, 0, N1, "R6");
    step(0, 1, N1, "R6");
    step(0, 1, N2, "R6");
    step(1, 0, 2'b00, "R7");

    // R5: repeated first number and other wrong values
    step(0, 1, N1, "R5");
    step(0, 1, N1, "R5");
    step(0, 0, 2'b00, "R6");
    step(1, 0, 2'b00, "R7");
    step(0, 1, N1, "R5");
    step(0, 1, 2'b00, "R5");
    step(1, 0, 2'b00, "R7");

    // R7: reset beats enter, entered number discarded
    step(1, 1, N1, "R7");
    step(0, 1, N2, "R7");
    step(1, 0, 2'b00, "R7");

    // R11: async clear from first-ok and from open
    step(0, 1, N1, "R11");
    async_clear("R11");
    step(0, 1, N2, "R11");
    step(1, 0, 2'b00, "R7");
    step(0, 1, N1, "R11");
    step(0, 1, N2, "R11");
    async_clear("R11");
    step(0, 0, 2'b00, "R11");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic r, e;
      logic [1:0] c;
      r = ($urandom % 10) == 0;
      e = ($urandom % 2) == 0;
      c = $urandom % 4;
      if (($urandom % 3) == 0) c = (mst == 0) ? N1 : N2;
      if (i % 500 == 499) async_clear("R11");
      else step(r, e, c, "R8");
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule